// File: doc/BRIEF.md
# Self-Timed Cyclo-Static Firing Controller

This block wraps the compute datapath of one streaming actor and sits between that datapath and the FIFOs on the actor's input and output channels. It has no central scheduler. In every clock cycle it works out on its own whether the actor may start a firing. Three conditions must all hold. Every input FIFO must hold enough tokens for the current firing. Every output FIFO must have enough free slots, counting slots already promised to firings still in the pipeline. The initiation-interval timer must have run out.

The number of tokens a firing takes and gives follows a fixed cyclic list of phases. Each phase count is scaled by a run-time rate value that is picked by index from a small fixed table. Software may write a new rate index at any time. The harness holds it in a shadow register and applies it only when an iteration ends, which is the firing of the last phase. A firing pulses the pop strobes of all inputs in the cycle it starts. The matching push strobes go out a fixed latency later, in firing order, so several firings can overlap when the interval is shorter than the latency.

Top module: `selftimed_actor_wrap`

## Requirements
- R1: No firing starts while any input level is below the current need. The need is PH_IN[phase] × RATE_SET[rate], where phase entry 0 is the least significant CNT_W field of PH_IN.
- R2: No firing starts while any output's free count, minus the tokens still owed to that output by firings in flight, is below PH_OUT[phase] × RATE_SET[rate].
- R3: Two firings are always at least II cycles apart (start to start).
- R4: The firing condition is checked in every cycle. A firing starts in the very first cycle in which R1, R2 and R3 are all met.
- R5: A firing pulses every in_pop bit together, with in_pop_cnt equal to the input need. Each firing moves the phase on by one, and the phase wraps from NUM_PH-1 back to 0.
- R6: Each firing leads to exactly one push on every output. The push comes EXEC cycles after the firing started, and out_push_cnt equals the output need of that firing. Pushes from overlapping firings come out in firing order.
- R7: A valid rate write takes effect only when a last-phase firing happens. The latest write wins. A write made in the same cycle as a last-phase firing applies at that boundary.
- R8: A rate write with an index of NUM_RATES or more is ignored, and the rate table value in use never changes because of it.
- R9: While rst_n is low, no strobe is driven. After reset the phase is 0, the rate index is DEF_RATE, the interval timer is clear and no push is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_level | input | N_IN*CNT_W | Token count held by each input FIFO |
| out_free | input | N_OUT*CNT_W | Free slots of each output FIFO |
| rate_wr | input | 1 | Rate index write strobe |
| rate_sel | input | RSEL_W | Rate index to write |
| fire | output | 1 | Firing start strobe to the datapath |
| cur_phase | output | PH_W | Phase of the next firing |
| cur_rate | output | RSEL_W | Rate index in use |
| in_pop | output | N_IN | Pop strobe for each input FIFO |
| in_pop_cnt | output | CNT_W | Tokens popped from each input on a firing |
| out_push | output | N_OUT | Push strobe for each output FIFO |
| out_push_cnt | output | CNT_W | Tokens pushed to each output |

## Verification
The bench starves the inputs until they sit exactly one token short of the need. A design that compares with the wrong bound, or checks only one channel, would fire here and pop tokens that do not exist. It also stops the output drain while pushes are still in flight. A design that ignores the tokens it still owes would then commit firings whose pushes overflow the output FIFO. Rate writes arrive mid-iteration, on the boundary cycle itself, and with an illegal index. A design that applied them at once, lost the same-cycle write or accepted the bad index would drift from the model in its pop counts. A reset in the middle of overlapping firings checks that pending pushes are dropped and the phase starts again from 0.

// File: rtl/sta_pkg.sv
`timescale 1ns/1ps
package sta_pkg;
   // Bits needed to index n distinct values (at least one bit).
   function automatic int sta_bits(input int n);
      return (n <= 2) ? 1 : $clog2(n);
   endfunction
endpackage

// File: rtl/sta_ii_timer.sv
`timescale 1ns/1ps
module sta_ii_timer import sta_pkg::*; #(
   parameter int II = 2,
   localparam int TW = sta_bits(II)
)(
   input  logic clk,
   input  logic rst_n,
   input  logic fire_i,
   output logic ready_o
);
   generate
      if (II <= 1) begin : g_free_run
         assign ready_o = 1'b1;
      end else begin : g_count
         logic [TW-1:0] left_q;
         always_ff @(posedge clk) begin
            if (!rst_n)                left_q <= '0;
            else if (fire_i)           left_q <= TW'(II - 1);
            else if (left_q != '0)     left_q <= left_q - 1'b1;
         end
         assign ready_o = (left_q == '0);

         AST_II_GAP: assert property (@(posedge clk) disable iff (!rst_n)
            fire_i |=> !fire_i); // R3
      end
   endgenerate
endmodule

// File: rtl/sta_phase_rate.sv
`timescale 1ns/1ps
module sta_phase_rate import sta_pkg::*; #(
   parameter int NUM_PH    = 3,
   parameter int NUM_RATES = 3,
   parameter int DEF_RATE  = 0,
   localparam int PH_W   = sta_bits(NUM_PH),
   localparam int RSEL_W = sta_bits(NUM_RATES)
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              adv_i,
   input  logic              wr_i,
   input  logic [RSEL_W-1:0] sel_i,
   output logic [PH_W-1:0]   phase_o,
   output logic [RSEL_W-1:0] rate_o
);
   localparam logic [PH_W-1:0] LAST = PH_W'(NUM_PH - 1);

   logic [RSEL_W-1:0] shadow_q;
   logic              wr_ok;
   logic              boundary;

   assign wr_ok    = wr_i && (int'(sel_i) < NUM_RATES);
   assign boundary = adv_i && (phase_o == LAST);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_o  <= '0;
         rate_o   <= RSEL_W'(DEF_RATE);
         shadow_q <= RSEL_W'(DEF_RATE);
      end else begin
         if (wr_ok) shadow_q <= sel_i;
         if (adv_i) begin
            if (phase_o == LAST) phase_o <= '0;
            else                 phase_o <= phase_o + 1'b1;
         end
         if (boundary) rate_o <= wr_ok ? sel_i : shadow_q;
      end
   end

   AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      adv_i |=> (phase_o == PH_W'((int'($past(phase_o)) + 1) % NUM_PH))); // R5
   AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !adv_i |=> $stable(phase_o)); // R5
   AST_RATE_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
      !boundary |=> $stable(rate_o)); // R7
   AST_RATE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      int'(rate_o) < NUM_RATES); // R8
endmodule

// File: rtl/sta_out_track.sv
`timescale 1ns/1ps
module sta_out_track #(
   parameter int N_OUT = 2,
   parameter int CNT_W = 6,
   parameter int EXEC  = 4,
   localparam int RW   = CNT_W + 1
)(
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   fire_i,
   input  logic [CNT_W-1:0]       cnt_i,
   input  logic [N_OUT*CNT_W-1:0] free_i,
   output logic                   room_o,
   output logic                   push_o,
   output logic [CNT_W-1:0]       push_cnt_o
);
   logic [EXEC-1:0]  st_vld;
   logic [CNT_W-1:0] st_cnt [EXEC];
   logic [N_OUT-1:0] room_v;

   // Latency line: one slot per cycle of execution time.
   always_ff @(posedge clk) begin
      if (!rst_n) st_vld <= '0;
      else begin
         st_vld[0] <= fire_i;
         for (int k = 1; k < EXEC; k++) st_vld[k] <= st_vld[k-1];
      end
   end
   always_ff @(posedge clk) begin
      st_cnt[0] <= cnt_i;
      for (int k = 1; k < EXEC; k++) st_cnt[k] <= st_cnt[k-1];
   end

   assign push_o     = st_vld[EXEC-1];
   assign push_cnt_o = st_cnt[EXEC-1];

   generate
      for (genvar o = 0; o < N_OUT; o++) begin : g_chan
         logic [RW-1:0]    owed_q;
         logic [CNT_W-1:0] free_o;
         assign free_o = free_i[o*CNT_W +: CNT_W];

         always_ff @(posedge clk) begin
            if (!rst_n) owed_q <= '0;
            else owed_q <= owed_q + (fire_i ? RW'(cnt_i) : '0)
                                  - (push_o ? RW'(push_cnt_o) : '0);
         end
         assign room_v[o] = ({1'b0, owed_q} + (RW+1)'(cnt_i)) <= (RW+1)'(free_o);

         AST_PUSH_FITS: assert property (@(posedge clk) disable iff (!rst_n)
            push_o |-> (free_o >= push_cnt_o)); // R2
         AST_OWED_COVERS: assert property (@(posedge clk) disable iff (!rst_n)
            push_o |-> (owed_q >= RW'(push_cnt_o))); // R6
      end
   endgenerate

   assign room_o = &room_v;
endmodule

// File: rtl/selftimed_actor_wrap.sv
`timescale 1ns/1ps
module selftimed_actor_wrap import sta_pkg::*; #(
   parameter int N_IN      = 2,
   parameter int N_OUT     = 2,
   parameter int CNT_W     = 6,
   parameter int NUM_PH    = 3,
   parameter logic [NUM_PH*CNT_W-1:0] PH_IN  = {6'd3, 6'd2, 6'd1},
   parameter logic [NUM_PH*CNT_W-1:0] PH_OUT = {6'd1, 6'd1, 6'd2},
   parameter int NUM_RATES = 3,
   parameter logic [NUM_RATES*CNT_W-1:0] RATE_SET = {6'd3, 6'd2, 6'd1},
   parameter int DEF_RATE  = 0,
   parameter int II        = 2,
   parameter int EXEC      = 4,
   localparam int PH_W   = sta_bits(NUM_PH),
   localparam int RSEL_W = sta_bits(NUM_RATES)
)(
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [N_IN*CNT_W-1:0]  in_level,
   input  logic [N_OUT*CNT_W-1:0] out_free,
   input  logic                   rate_wr,
   input  logic [RSEL_W-1:0]      rate_sel,
   output logic                   fire,
   output logic [PH_W-1:0]        cur_phase,
   output logic [RSEL_W-1:0]      cur_rate,
   output logic [N_IN-1:0]        in_pop,
   output logic [CNT_W-1:0]       in_pop_cnt,
   output logic [N_OUT-1:0]       out_push,
   output logic [CNT_W-1:0]       out_push_cnt
);
   localparam int CMAX = (1 << CNT_W) - 1;

   // Elaboration-time parameter checks.
   generate
      if (N_IN < 1 || N_OUT < 1)         begin : g_bad_ch   $error("channel counts must be positive"); end
      if (II < 1)                        begin : g_bad_ii   $error("II must be at least 1"); end
      if (EXEC < 1 || EXEC > 64)         begin : g_bad_exec $error("EXEC must be within 1..64"); end
      if (DEF_RATE >= NUM_RATES)         begin : g_bad_def  $error("DEF_RATE out of range"); end
      for (genvar p = 0; p < NUM_PH; p++) begin : g_chk_p
         for (genvar r = 0; r < NUM_RATES; r++) begin : g_chk_r
            if (int'(PH_IN[p*CNT_W +: CNT_W]) * int'(RATE_SET[r*CNT_W +: CNT_W]) > CMAX ||
                int'(PH_OUT[p*CNT_W +: CNT_W]) * int'(RATE_SET[r*CNT_W +: CNT_W]) > CMAX)
            begin : g_ovf $error("phase count times rate exceeds CNT_W"); end
         end
      end
   endgenerate

   // Lookup tables built from the packed parameters.
   logic [CNT_W-1:0] in_tab   [NUM_PH];
   logic [CNT_W-1:0] out_tab  [NUM_PH];
   logic [CNT_W-1:0] rate_tab [NUM_RATES];
   generate
      for (genvar p = 0; p < NUM_PH; p++) begin : g_ph_tab
         assign in_tab[p]  = PH_IN[p*CNT_W +: CNT_W];
         assign out_tab[p] = PH_OUT[p*CNT_W +: CNT_W];
      end
      for (genvar r = 0; r < NUM_RATES; r++) begin : g_rate_tab
         assign rate_tab[r] = RATE_SET[r*CNT_W +: CNT_W];
      end
   endgenerate

   logic [CNT_W-1:0] need_in, need_out;
   logic [N_IN-1:0]  in_ok;
   logic             room, ii_rdy, push_raw;

   assign need_in  = in_tab[cur_phase]  * rate_tab[cur_rate];
   assign need_out = out_tab[cur_phase] * rate_tab[cur_rate];

   generate
      for (genvar i = 0; i < N_IN; i++) begin : g_in
         assign in_ok[i] = in_level[i*CNT_W +: CNT_W] >= need_in;

         AST_NO_UNDERRUN: assert property (@(posedge clk) disable iff (!rst_n)
            in_pop[i] |-> (in_level[i*CNT_W +: CNT_W] >= in_pop_cnt)); // R1
      end
   endgenerate

   assign fire = rst_n && (&in_ok) && room && ii_rdy;

   sta_ii_timer #(.II(II)) u_timer (
      .clk(clk), .rst_n(rst_n), .fire_i(fire), .ready_o(ii_rdy));

   sta_phase_rate #(.NUM_PH(NUM_PH), .NUM_RATES(NUM_RATES), .DEF_RATE(DEF_RATE)) u_seq (
      .clk(clk), .rst_n(rst_n), .adv_i(fire), .wr_i(rate_wr), .sel_i(rate_sel),
      .phase_o(cur_phase), .rate_o(cur_rate));

   sta_out_track #(.N_OUT(N_OUT), .CNT_W(CNT_W), .EXEC(EXEC)) u_out (
      .clk(clk), .rst_n(rst_n), .fire_i(fire), .cnt_i(need_out), .free_i(out_free),
      .room_o(room), .push_o(push_raw), .push_cnt_o(out_push_cnt));

   assign in_pop     = {N_IN{fire}};
   assign in_pop_cnt = need_in;
   assign out_push   = {N_OUT{push_raw && rst_n}};

   AST_POP_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
      (in_pop != '0) |-> (&in_pop)); // R5
   AST_PUSH_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
      (out_push != '0) |-> (&out_push)); // R6
endmodule

// File: tb/tb_selftimed_actor_wrap.sv
`timescale 1ns/1ps
module tb_selftimed_actor_wrap;
   localparam int N_IN = 2, N_OUT = 2, CW = 6, NPH = 3, NR = 3, DEF = 1;
   localparam int II = 2, EXEC = 4, IN_DEPTH = 40, OUT_DEPTH = 16, NCYC = 2600;

   int ph_in  [NPH] = '{1, 2, 3};
   int ph_out [NPH] = '{2, 1, 1};
   int rates  [NR]  = '{1, 2, 3};

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic rst_n, rate_wr, fire;
   logic [1:0] rate_sel, cur_phase, cur_rate;
   logic [N_IN*CW-1:0]  in_level;
   logic [N_OUT*CW-1:0] out_free;
   logic [N_IN-1:0]  in_pop;
   logic [N_OUT-1:0] out_push;
   logic [CW-1:0] in_pop_cnt, out_push_cnt;

   int lvl [N_IN];
   int fre [N_OUT];
   always_comb begin
      for (int i = 0; i < N_IN; i++)  in_level[i*CW +: CW] = CW'(lvl[i]);
      for (int o = 0; o < N_OUT; o++) out_free[o*CW +: CW] = CW'(fre[o]);
   end

   selftimed_actor_wrap #(
      .N_IN(N_IN), .N_OUT(N_OUT), .CNT_W(CW), .NUM_PH(NPH),
      .PH_IN({6'd3, 6'd2, 6'd1}), .PH_OUT({6'd1, 6'd1, 6'd2}),
      .NUM_RATES(NR), .RATE_SET({6'd3, 6'd2, 6'd1}), .DEF_RATE(DEF),
      .II(II), .EXEC(EXEC)
   ) dut (
      .clk(clk), .rst_n(rst_n), .in_level(in_level), .out_free(out_free),
      .rate_wr(rate_wr), .rate_sel(rate_sel), .fire(fire),
      .cur_phase(cur_phase), .cur_rate(cur_rate), .in_pop(in_pop),
      .in_pop_cnt(in_pop_cnt), .out_push(out_push), .out_push_cnt(out_push_cnt));

   int total = 0, errs = 0;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         errs++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      chk(1'b0, "watchdog", 0, 1);
      $display("%0d/%0d checks passed", total - errs, total);
      $finish;
   end

   // Reference model state
   int rphase, rrate, rsh, rii, rsv;
   int due_q[$], cnt_q[$];
   int nlvl [N_IN];
   int nfre [N_OUT];
   bit bad_wr_seen, was_reset;

   initial begin
      rst_n = 1'b0; rate_wr = 1'b0; rate_sel = '0;
      for (int i = 0; i < N_IN; i++)  begin lvl[i] = 0; nlvl[i] = 0; end
      for (int o = 0; o < N_OUT; o++) begin fre[o] = OUT_DEPTH; nfre[o] = OUT_DEPTH; end
      rphase = 0; rrate = DEF; rsh = DEF; rii = 0; rsv = 0;
      bad_wr_seen = 0; was_reset = 1;

      for (int cyc = 0; cyc < NCYC; cyc++) begin
         int need_i, need_o, pmax, cmax;
         bit in_short, out_short, efire, epush, bnd, wr_ok;
         int epcnt;
         @(negedge clk);
         for (int i = 0; i < N_IN; i++)  lvl[i] = nlvl[i];
         for (int o = 0; o < N_OUT; o++) fre[o] = nfre[o];
         rst_n = !(cyc < 3 || (cyc >= 1500 && cyc < 1503));
         rate_wr = 1'b0;
         if (cyc == 40)      begin rate_wr = 1'b1; rate_sel = 2'd2; end
         else if (cyc == 60) begin rate_wr = 1'b1; rate_sel = 2'd3; end
         else if (cyc % 17 == 5) begin rate_wr = 1'b1; rate_sel = 2'($urandom % 4); end
         #1;

         need_i = ph_in[rphase] * rates[rrate];
         need_o = ph_out[rphase] * rates[rrate];
         in_short = 0; out_short = 0;
         for (int i = 0; i < N_IN; i++)  if (lvl[i] < need_i) in_short = 1;
         for (int o = 0; o < N_OUT; o++) if (fre[o] - rsv < need_o) out_short = 1;
         efire = rst_n && !in_short && !out_short && (rii == 0);
         epush = rst_n && due_q.size() > 0 && due_q[0] == cyc;
         epcnt = epush ? cnt_q[0] : 0;

         if (rst_n && was_reset) begin
            chk(cur_phase == 2'd0, "R9 phase after reset", int'(cur_phase), 0);
            chk(int'(cur_rate) == DEF, "R9 rate after reset", int'(cur_rate), DEF);
         end
         if (!rst_n) begin
            chk(fire == 1'b0, "R9 no fire in reset", int'(fire), 0);
            chk(out_push == '0, "R9 no push in reset", int'(out_push), 0);
         end else begin
            string ftag;
            if (in_short)       ftag = "R1 fire vs input level";
            else if (out_short) ftag = "R2 fire vs output room";
            else if (rii != 0)  ftag = "R3 fire vs interval";
            else                ftag = "R4 fire when ready";
            chk(fire == efire, ftag, int'(fire), int'(efire));
            chk(in_pop == {N_IN{efire}}, "R5 pop strobes", int'(in_pop), efire ? 3 : 0);
            if (efire) chk(int'(in_pop_cnt) == need_i, "R5 pop count", int'(in_pop_cnt), need_i);
            chk(int'(cur_phase) == rphase, "R5 phase", int'(cur_phase), rphase);
            chk(int'(cur_rate) == rrate, bad_wr_seen ? "R8 rate after bad write" : "R7 rate",
                int'(cur_rate), rrate);
            chk(out_push == {N_OUT{epush}}, "R6 push strobes", int'(out_push), epush ? 3 : 0);
            if (epush) chk(int'(out_push_cnt) == epcnt, "R6 push count", int'(out_push_cnt), epcnt);
         end

         // Reference state update for the coming edge
         for (int i = 0; i < N_IN; i++)  nlvl[i] = lvl[i];
         for (int o = 0; o < N_OUT; o++) nfre[o] = fre[o];
         if (!rst_n) begin
            rphase = 0; rrate = DEF; rsh = DEF; rii = 0; rsv = 0;
            due_q.delete(); cnt_q.delete(); bad_wr_seen = 0; was_reset = 1;
         end else begin
            was_reset = 0;
            wr_ok = rate_wr && (int'(rate_sel) < NR);
            if (rate_wr && !wr_ok) bad_wr_seen = 1;
            bnd = efire && (rphase == NPH - 1);
            if (efire) begin
               for (int i = 0; i < N_IN; i++) nlvl[i] -= need_i;
               due_q.push_back(cyc + EXEC); cnt_q.push_back(need_o);
               rsv += need_o;
               rphase = (rphase + 1) % NPH;
               rii = II - 1;
            end else if (rii > 0) rii--;
            if (epush) begin
               for (int o = 0; o < N_OUT; o++) nfre[o] -= epcnt;
               rsv -= epcnt;
               void'(due_q.pop_front()); void'(cnt_q.pop_front());
            end
            if (bnd) begin
               rrate = wr_ok ? int'(rate_sel) : rsh;
               bad_wr_seen = 0;
            end
            if (wr_ok) rsh = int'(rate_sel);
         end

         // Environment: producers fill inputs, consumers drain outputs
         if (cyc < 400)                     pmax = 4;
         else if (cyc < 700)                pmax = (cyc % 3 == 0) ? 1 : 0;
         else                               pmax = 3;
         if (cyc >= 700 && cyc < 1000)      cmax = 0;
         else if (cyc < 400)                cmax = 6;
         else                               cmax = 2;
         for (int i = 0; i < N_IN; i++) begin
            int a;
            a = $urandom_range(pmax, 0);
            nlvl[i] = (nlvl[i] + a > IN_DEPTH) ? IN_DEPTH : nlvl[i] + a;
         end
         for (int o = 0; o < N_OUT; o++) begin
            int t;
            t = $urandom_range(cmax, 0);
            if (t > OUT_DEPTH - nfre[o]) t = OUT_DEPTH - nfre[o];
            nfre[o] += t;
         end
      end
      $display("%0d/%0d checks passed", total - errs, total);
      $finish;
   end
endmodule